// File: doc/BRIEF.md
# Harness Continuity Fault Classifier

This block judges one step of a wiring harness continuity test. For each step, the driving side places a pattern on the harness in which exactly one line differs from all the others. The receiving side captures the levels seen at the far end of every line. The classifier takes the index of the line under test, the polarity of the pattern and the captured word. One clock later it reports whether the tested line passed, is open, or is shorted to other lines. It also gives a mask of every other line that showed an unexpected level.

A polarity flag selects the pattern type:
- Polarity 0 is the true pattern. Only the tested line is driven to logic 1.
- Polarity 1 is the complementary pattern. Only the tested line is at logic 0 and every other line is at 1. This is the pattern seen with pulled-up lines and a single line pulled low.

Each line is normally tested twice in a row, once with each polarity. The block keeps the first result of such a pair pending. When the second half arrives, it reports a confirmed verdict. If the two halves disagree, it reports noise, which points to coupling or an intermittent contact.

A line index at or above the configured line count is rejected with an error flag.

Top module: `harness_fault_classifier`

## Requirements
- R1: When the tested line alone shows the active level and every other line shows the idle level, the class is PASS (code 0) and the mask is zero.
- R2: When the tested line shows the active level and other lines also deviate from the expected pattern, the class is SHORT (code 2). Those lines are set in the mask, with bit i of the mask standing for line i.
- R3: When the tested line does not show the active level, the class is OPEN (code 1). OPEN takes priority over SHORT, and the mask still lists any other deviating lines.
- R4: With polarity 0 the expected word has only the tested bit at 1 and the active level is 1. With polarity 1 the expected word is its bitwise complement and the active level is 0.
- R5: The mask equals the received word XOR the expected word, with the tested line's own bit forced to 0.
- R6: A result is registered. `res_valid` is high exactly in the cycle after a cycle with `cmp_valid` high, and low otherwise.
- R7: A strobe for the same line as a pending first half, with the opposite polarity, closes the pair. Its result has `res_final` set, and the pending half is consumed.
- R8: When both halves of a pair give the same class and the same mask, the final result carries that class and mask.
- R9: When the halves of a pair differ in class or mask, the final class is NOISE (code 3) and the mask is the OR of both masks.
- R10: A line index of `N_LINES` or more sets `res_err`, reports class PASS, a zero mask and `res_final` low, and discards any pending half.
- R11: After reset, `res_valid`, `res_final` and `res_err` are low, the class is PASS and the mask is zero. No half is pending.
- R12: A valid in-range strobe that does not close a pair reports its own single result with `res_final` low. It then becomes the pending half, replacing any earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Compare strobe, one cycle per test step |
| cmp_line | input | IDX_W | Index of the line under test |
| cmp_inv | input | 1 | Pattern polarity: 0 single one, 1 single zero |
| rx_word | input | N_LINES | Levels captured at the far end of the harness |
| res_valid | output | 1 | Result strobe, one cycle after `cmp_valid` |
| res_class | output | 2 | 0 PASS, 1 OPEN, 2 SHORT, 3 NOISE |
| res_mask | output | N_LINES | Lines that deviated from the expected pattern |
| res_final | output | 1 | Result closes a two-polarity pair |
| res_err | output | 1 | Line index out of range |

## Verification
The assertions assume two things about the inputs:
- `cmp_valid` is a clean strobe with known line, polarity and word values whenever it is high.
- The tested-bit exclusion and the SHORT mask are only meaningful for in-range indices, so the mask checks are guarded by the range test.

The stimulus keeps within this. It drives every input on the falling edge with fully defined values. The random line index mostly stays in range, with occasional out-of-range values. Polarity usually alternates and the index usually repeats, so that complete pairs, broken pairs and mismatched halves all occur often.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    typedef enum logic [1:0] {
        FC_PASS  = 2'd0,
        FC_OPEN  = 2'd1,
        FC_SHORT = 2'd2,
        FC_NOISE = 2'd3
    } fclass_e;

endpackage

// File: rtl/hcf_expect.sv
module hcf_expect #(
    parameter int N_LINES = 12,
    parameter int IDX_W   = 4
) (
    input  logic [IDX_W-1:0]   line_idx,
    output logic [N_LINES-1:0] onehot,
    output logic               in_range
);
    localparam logic [N_LINES-1:0] ONE = {{(N_LINES-1){1'b0}}, 1'b1};

    always_comb begin
        in_range = (32'(line_idx) < N_LINES);
        onehot   = in_range ? (ONE << line_idx) : '0;
    end
endmodule

// File: rtl/hcf_compare.sv
module hcf_compare
    import hcf_pkg::*;
#(
    parameter int N_LINES = 12
) (
    input  logic [N_LINES-1:0] onehot,
    input  logic               inv,
    input  logic [N_LINES-1:0] rx_word,
    output fclass_e            cls,
    output logic [N_LINES-1:0] mask
);
    logic [N_LINES-1:0] expect_w;
    logic               tested_ok;

    always_comb begin
        expect_w  = inv ? ~onehot : onehot;
        mask      = (rx_word ^ expect_w) & ~onehot;
        tested_ok = inv ? ~|(rx_word & onehot) : |(rx_word & onehot);
        if (!tested_ok)
            cls = FC_OPEN;
        else if (|mask)
            cls = FC_SHORT;
        else
            cls = FC_PASS;
    end
endmodule

// File: rtl/hcf_pair.sv
module hcf_pair
    import hcf_pkg::*;
#(
    parameter int N_LINES = 12,
    parameter int IDX_W   = 4
) (
    input  logic               pend_vld,
    input  logic [IDX_W-1:0]   pend_line,
    input  logic               pend_inv,
    input  fclass_e            pend_cls,
    input  logic [N_LINES-1:0] pend_mask,
    input  logic [IDX_W-1:0]   cur_line,
    input  logic               cur_inv,
    input  logic               cur_ok,
    input  fclass_e            cur_cls,
    input  logic [N_LINES-1:0] cur_mask,
    output logic               hit,
    output fclass_e            comb_cls,
    output logic [N_LINES-1:0] comb_mask
);
    logic agree;

    always_comb begin
        hit       = pend_vld && cur_ok && (pend_line == cur_line) && (pend_inv != cur_inv);
        agree     = (pend_cls == cur_cls) && (pend_mask == cur_mask);
        comb_cls  = agree ? cur_cls : FC_NOISE;
        comb_mask = agree ? cur_mask : (pend_mask | cur_mask);
    end
endmodule

// File: rtl/harness_fault_classifier.sv
module harness_fault_classifier
    import hcf_pkg::*;
#(
    parameter int N_LINES = 12,
    parameter int IDX_W   = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_valid,
    input  logic [IDX_W-1:0]   cmp_line,
    input  logic               cmp_inv,
    input  logic [N_LINES-1:0] rx_word,
    output logic               res_valid,
    output logic [1:0]         res_class,
    output logic [N_LINES-1:0] res_mask,
    output logic               res_final,
    output logic               res_err
);
    typedef struct packed {
        logic               res_vld;
        fclass_e            res_cls;
        logic [N_LINES-1:0] res_mask;
        logic               res_fin;
        logic               res_err;
        logic               pend_vld;
        logic [IDX_W-1:0]   pend_line;
        logic               pend_inv;
        fclass_e            pend_cls;
        logic [N_LINES-1:0] pend_mask;
    } state_t;

    state_t st_d, st_q;

    logic [N_LINES-1:0] onehot;
    logic               in_range;
    fclass_e            single_cls;
    logic [N_LINES-1:0] single_mask;
    logic               pair_hit;
    fclass_e            pair_cls;
    logic [N_LINES-1:0] pair_mask;

    hcf_expect #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_expect (
        .line_idx (cmp_line),
        .onehot   (onehot),
        .in_range (in_range)
    );

    hcf_compare #(.N_LINES(N_LINES)) u_compare (
        .onehot  (onehot),
        .inv     (cmp_inv),
        .rx_word (rx_word),
        .cls     (single_cls),
        .mask    (single_mask)
    );

    hcf_pair #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_pair (
        .pend_vld  (st_q.pend_vld),
        .pend_line (st_q.pend_line),
        .pend_inv  (st_q.pend_inv),
        .pend_cls  (st_q.pend_cls),
        .pend_mask (st_q.pend_mask),
        .cur_line  (cmp_line),
        .cur_inv   (cmp_inv),
        .cur_ok    (in_range),
        .cur_cls   (single_cls),
        .cur_mask  (single_mask),
        .hit       (pair_hit),
        .comb_cls  (pair_cls),
        .comb_mask (pair_mask)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res_vld = 1'b0;
        if (cmp_valid) begin
            st_d.res_vld = 1'b1;
            if (!in_range) begin
                st_d.res_cls  = FC_PASS;
                st_d.res_mask = '0;
                st_d.res_fin  = 1'b0;
                st_d.res_err  = 1'b1;
                st_d.pend_vld = 1'b0;
            end else if (pair_hit) begin
                st_d.res_cls  = pair_cls;
                st_d.res_mask = pair_mask;
                st_d.res_fin  = 1'b1;
                st_d.res_err  = 1'b0;
                st_d.pend_vld = 1'b0;
            end else begin
                st_d.res_cls   = single_cls;
                st_d.res_mask  = single_mask;
                st_d.res_fin   = 1'b0;
                st_d.res_err   = 1'b0;
                st_d.pend_vld  = 1'b1;
                st_d.pend_line = cmp_line;
                st_d.pend_inv  = cmp_inv;
                st_d.pend_cls  = single_cls;
                st_d.pend_mask = single_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{res_vld: 1'b0, res_cls: FC_PASS, res_mask: '0, res_fin: 1'b0,
                      res_err: 1'b0, pend_vld: 1'b0, pend_line: '0, pend_inv: 1'b0,
                      pend_cls: FC_PASS, pend_mask: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_vld;
    assign res_class = st_q.res_cls;
    assign res_mask  = st_q.res_mask;
    assign res_final = st_q.res_fin;
    assign res_err   = st_q.res_err;

    // R6: result strobe follows the compare strobe by one cycle
    p_strobe_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> res_valid);
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !res_valid);
    // R1: a pass never carries deviating lines
    p_pass_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == 2'd0) |-> (res_mask == '0));
    // R2: a short always names at least one line
    p_short_named_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == 2'd2) |-> (res_mask != '0));
    // R5: the tested line never appears in its own mask
    p_tested_excluded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && in_range) |=> ((res_mask & $past(onehot)) == '0));
    // R9: noise only comes from a completed pair
    p_noise_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == 2'd3) |-> res_final);
    // R10: a rejected index gives an empty, non-final result
    p_err_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (res_mask == '0 && res_class == 2'd0 && !res_final));

endmodule

// File: tb/harness_fault_classifier_test.sv
module harness_fault_classifier_test;
    localparam int N  = 12;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [IW-1:0] cmp_line = '0;
    logic          cmp_inv = 1'b0;
    logic [N-1:0]  rx_word = '0;
    logic          res_valid;
    logic [1:0]    res_class;
    logic [N-1:0]  res_mask;
    logic          res_final;
    logic          res_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of the pending half
    bit           m_pv = 1'b0;
    int           m_pl = 0;
    bit           m_pi = 1'b0;
    int           m_pc = 0;
    logic [N-1:0] m_pm = '0;

    always #10 clk = ~clk;

    harness_fault_classifier #(.N_LINES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_line(cmp_line),
        .cmp_inv(cmp_inv), .rx_word(rx_word), .res_valid(res_valid),
        .res_class(res_class), .res_mask(res_mask), .res_final(res_final),
        .res_err(res_err)
    );

    task automatic check(string tag, logic v, logic [1:0] c, logic [N-1:0] m, logic f, logic e);
        n_tests++;
        if (res_valid !== v || res_class !== c || res_mask !== m || res_final !== f || res_err !== e) begin
            n_fail++;
            $display("FAIL %s: got v=%b c=%0d m=%h f=%b e=%b, expected v=%b c=%0d m=%h f=%b e=%b",
                     tag, res_valid, res_class, res_mask, res_final, res_err, v, c, m, f, e);
        end
    endtask

    // single-step verdict computed bit by bit
    function automatic void judge(int line, bit inv, logic [N-1:0] rx, output int cls, output logic [N-1:0] m);
        bit act = inv ? 1'b0 : 1'b1;
        m = '0;
        for (int i = 0; i < N; i++)
            if (i != line && rx[i] == act) m[i] = 1'b1;
        if (rx[line] != act) cls = 1;
        else if (m != '0) cls = 2;
        else cls = 0;
    endfunction

    task automatic step(string tag, int line, bit inv, logic [N-1:0] rx);
        int           c, oc;
        logic [N-1:0] m, om;
        bit           f, e;
        cmp_line  = IW'(line);
        cmp_inv   = inv;
        rx_word   = rx;
        cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        e = (line >= N);
        f = 1'b0;
        if (e) begin
            oc = 0; om = '0; m_pv = 1'b0;
        end else begin
            judge(line, inv, rx, c, m);
            if (m_pv && m_pl == line && m_pi != inv) begin
                f = 1'b1;
                if (c == m_pc && m == m_pm) begin oc = c; om = m; end
                else begin oc = 3; om = m | m_pm; end
                m_pv = 1'b0;
            end else begin
                oc = c; om = m;
                m_pv = 1'b1; m_pl = line; m_pi = inv; m_pc = c; m_pm = m;
            end
        end
        check(tag, 1'b1, 2'(oc), om, f, e);
    endtask

    function automatic logic [N-1:0] bit_of(int i);
        return N'(1) << i;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got no end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int           seed = 32'h5eed;
        int           line, prev_line;
        bit           inv, prev_inv;
        logic [N-1:0] rx;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R11 reset", 1'b0, 2'd0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", 1'b0, 2'd0, '0, 1'b0, 1'b0);

        step("R1 R4 true pass", 2, 1'b0, bit_of(2));
        step("R7 R8 R4 complement pass", 2, 1'b1, ~bit_of(2));
        @(negedge clk);
        check("R6 idle cycle", 1'b0, 2'd0, bit_of(2) & '0, 1'b1, 1'b0);
        step("R2 R5 short complement", 1, 1'b1, ~(bit_of(1) | bit_of(2)));
        step("R2 R8 short true", 1, 1'b0, bit_of(1) | bit_of(2));
        step("R3 open complement", 3, 1'b1, '1);
        step("R3 R8 open true", 3, 1'b0, '0);
        step("R3 open over short", 0, 1'b0, bit_of(5));
        step("R12 different line", 5, 1'b0, bit_of(5));
        step("R9 noise", 5, 1'b1, ~(bit_of(5) | bit_of(6)));
        step("R12 first half", 4, 1'b0, bit_of(4));
        step("R10 out of range", 13, 1'b0, '0);
        step("R10 pending cleared", 4, 1'b1, ~bit_of(4));
        step("R12 same polarity", 7, 1'b0, bit_of(7));
        step("R12 same polarity again", 7, 1'b0, bit_of(7));
        step("R7 top line pair", N - 1, 1'b1, ~bit_of(N - 1));

        prev_line = 0;
        prev_inv  = 1'b0;
        for (int k = 0; k < 600; k++) begin
            if ($urandom % 10 < 6) line = prev_line;
            else if ($urandom % 12 == 0) line = N + ($urandom % (16 - N));
            else line = $urandom % N;
            inv = ($urandom % 10 < 7) ? ~prev_inv : prev_inv;
            rx  = (line < N) ? (inv ? ~bit_of(line) : bit_of(line)) : N'($urandom);
            case ($urandom % 4)
                0: ;
                1: rx = rx ^ bit_of($urandom % N);
                2: rx = rx ^ (N'($urandom) & N'($urandom));
                default: rx = N'($urandom);
            endcase
            step("R5 R8 R9 random", line, inv, rx);
            prev_line = line;
            prev_inv  = inv;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule